// File: doc/BRIEF.md
# Pointer-Register Data Address Generator

This block produces data-memory addresses for a processor core. It holds eight 16-bit pointer registers and a 3-bit selector that names the active one. In pointer mode the active register's present value is driven out as the address, and on the following clock edge that register is stepped. The step can be nothing, plus one, minus one, plus register zero or minus register zero, and all of this arithmetic is unsigned and wraps modulo 2^16. In page mode the address is built from a 9-bit page register placed above the seven low bits of the instruction word.

A third mode compares the active register with register zero under one of four conditions and stores the outcome in a flag. A write port loads any pointer register. The selector and the page register each have their own load input. Memory is outside the block.

Top module: `ptr_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears all eight pointer registers, the selector, the page register and the compare flag to zero.
- R2: With `acc_mode`=1 (pointer), `addr` equals the value the selected register holds before its update and `addr_valid` is 1, in the same cycle and without a register stage.
- R3: In pointer mode the selected register takes, at the next clock edge, the value given by `step_code`: 0 keep, 1 add one, 2 subtract one, 3 add register zero, 4 subtract register zero, and 5 to 7 keep.
- R4: Pointer arithmetic wraps modulo 2^16, so 0xFFFF plus one gives 0x0000 and 0x0000 minus one gives 0xFFFF.
- R5: With `acc_mode`=2 (page), `addr` is the page register in bits 15:7 and `instr_off[6:0]` in bits 6:0, and `addr_valid` is 1.
- R6: `page_load` writes `page_val` into the page register at the clock edge. A page access in that same cycle still uses the old page.
- R7: `sel_load` writes `sel_val` into the selector at the clock edge. An access in that same cycle uses the old selector, and the next access uses the new one.
- R8: With `acc_mode`=3 (compare), `cmp_flag` takes, at the next edge, the result of comparing the selected register with register zero as unsigned values. The condition is set by `cmp_cond`: 0 equal, 1 less than, 2 greater than, 3 not equal. In other modes the flag holds. Compare mode changes no pointer register and drives `addr`=0 with `addr_valid`=0.
- R9: When `reg_we` is 1, `reg_wdata` is written into register `reg_widx`. If the same register is also being stepped in that cycle, the write wins.
- R10: With `acc_mode`=0 (idle), `addr` is 0, `addr_valid` is 0, and no pointer register changes, whatever `step_code` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_mode | input | 2 | 0 idle, 1 pointer, 2 page, 3 compare |
| step_code | input | 3 | Post-access update of the selected register |
| cmp_cond | input | 2 | Compare condition |
| sel_load | input | 1 | Load the selector |
| sel_val | input | 3 | New selector value |
| page_load | input | 1 | Load the page register |
| page_val | input | 9 | New page value |
| reg_we | input | 1 | Pointer register write enable |
| reg_widx | input | 3 | Register to write |
| reg_wdata | input | 16 | Write data |
| instr_off | input | 7 | Low instruction bits for page mode |
| addr | output | 16 | Data address |
| addr_valid | output | 1 | Address is meaningful this cycle |
| cmp_flag | output | 1 | Registered compare result |

## Verification
Two pairs of actions can fall in one cycle. The first pair is a pointer step and a port write to the same register. The bench applies a step-by-one and a write to that register in one vector, then reads the register back through a later pointer access and expects the written value, not the stepped one. The second pair is a selector or page reload together with an access. There the bench expects the address of the old selector or page in that cycle and the new one in the following cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int NREG  = 8;
    localparam int DW    = 16;
    localparam int PGW   = 9;
    localparam int SELW  = $clog2(NREG);
    localparam int OFW   = DW - PGW;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_PTR  = 2'd1,
        M_PAGE = 2'd2,
        M_CMP  = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        U_KEEP = 3'd0,
        U_INC  = 3'd1,
        U_DEC  = 3'd2,
        U_ADDZ = 3'd3,
        U_SUBZ = 3'd4
    } step_e;

    typedef enum logic [1:0] {
        C_EQ = 2'd0,
        C_LT = 2'd1,
        C_GT = 2'd2,
        C_NE = 2'd3
    } cond_e;

    function automatic logic [DW-1:0] step_value(
        input logic [DW-1:0] cur,
        input logic [DW-1:0] zreg,
        input logic [2:0]    code
    );
        case (code)
            U_INC:   return cur + DW'(1);
            U_DEC:   return cur - DW'(1);
            U_ADDZ:  return cur + zreg;
            U_SUBZ:  return cur - zreg;
            default: return cur;
        endcase
    endfunction

    function automatic logic cond_true(
        input logic [DW-1:0] a,
        input logic [DW-1:0] b,
        input logic [1:0]    c
    );
        case (c)
            C_EQ:    return a == b;
            C_LT:    return a < b;
            C_GT:    return a > b;
            default: return a != b;
        endcase
    endfunction

endpackage

// File: rtl/agu_regfile.sv
module agu_regfile
    import agu_pkg::*;
#(
    parameter int N  = NREG,
    parameter int W  = DW,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic          upd_en,
    input  logic [IW-1:0] upd_idx,
    input  logic [W-1:0]  upd_val,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    output logic [W-1:0]  zero_data
);

    logic [N-1:0][W-1:0] regs;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (we && widx == IW'(i))
                    regs[i] <= wdata;
                else if (upd_en && upd_idx == IW'(i))
                    regs[i] <= upd_val;
            end
        end
    end

    assign rd_data   = regs[rd_idx];
    assign zero_data = regs[0];

    // R9: port write beats a step aimed at the same register
    a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
        (we && upd_en && widx == upd_idx) |=> regs[$past(widx)] == $past(wdata));

    // R3: an unopposed step lands in the stepped register
    a_r3_step_lands: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !(we && widx == upd_idx)) |=> regs[$past(upd_idx)] == $past(upd_val));

    // R1: reset leaves every register at zero
    a_r1_regs_clear: assert property (@(posedge clk)
        rst |=> regs == '0);

endmodule

// File: rtl/agu_step.sv
module agu_step
    import agu_pkg::*;
(
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] zreg,
    input  logic [2:0]    code,
    input  logic [1:0]    cond,
    output logic [DW-1:0] nxt,
    output logic          hit
);

    always_comb begin
        nxt = step_value(cur, zreg, code);
        hit = cond_true(cur, zreg, cond);
    end

    // R4: wrap at both ends of the unsigned range
    always_comb begin
        if (code == U_INC && cur == '1)
            a_r4_wrap_up: assert (nxt == '0);
        if (code == U_DEC && cur == '0)
            a_r4_wrap_down: assert (nxt == '1);
    end

endmodule

// File: rtl/agu_page.sv
module agu_page
    import agu_pkg::*;
#(
    parameter int PW = PGW,
    parameter int OW = OFW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [PW-1:0]  val,
    input  logic [OW-1:0]  off,
    output logic [PW+OW-1:0] daddr
);

    logic [PW-1:0] page_q;

    always_ff @(posedge clk) begin
        if (rst)
            page_q <= '0;
        else if (load)
            page_q <= val;
    end

    assign daddr = {page_q, off};

    // R6: a load becomes visible one edge later
    a_r6_page_load: assert property (@(posedge clk) disable iff (rst)
        load |=> daddr[PW+OW-1:OW] == $past(val));

    a_r6_page_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(page_q));

endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
    import agu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  acc_mode,
    input  logic [2:0]  step_code,
    input  logic [1:0]  cmp_cond,
    input  logic        sel_load,
    input  logic [2:0]  sel_val,
    input  logic        page_load,
    input  logic [8:0]  page_val,
    input  logic        reg_we,
    input  logic [2:0]  reg_widx,
    input  logic [15:0] reg_wdata,
    input  logic [6:0]  instr_off,
    output logic [15:0] addr,
    output logic        addr_valid,
    output logic        cmp_flag
);

    logic [SELW-1:0] sel_q;
    logic [DW-1:0]   cur_val;
    logic [DW-1:0]   zero_val;
    logic [DW-1:0]   nxt_val;
    logic            cmp_hit;
    logic [DW-1:0]   page_addr;
    mode_e           mode;

    assign mode = mode_e'(acc_mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= '0;
            cmp_flag <= 1'b0;
        end else begin
            if (sel_load)
                sel_q <= sel_val;
            if (mode == M_CMP)
                cmp_flag <= cmp_hit;
        end
    end

    agu_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .widx      (reg_widx),
        .wdata     (reg_wdata),
        .upd_en    (mode == M_PTR),
        .upd_idx   (sel_q),
        .upd_val   (nxt_val),
        .rd_idx    (sel_q),
        .rd_data   (cur_val),
        .zero_data (zero_val)
    );

    agu_step u_step (
        .cur  (cur_val),
        .zreg (zero_val),
        .code (step_code),
        .cond (cmp_cond),
        .nxt  (nxt_val),
        .hit  (cmp_hit)
    );

    agu_page u_page (
        .clk   (clk),
        .rst   (rst),
        .load  (page_load),
        .val   (page_val),
        .off   (instr_off),
        .daddr (page_addr)
    );

    always_comb begin
        unique case (mode)
            M_PTR:   begin addr = cur_val;   addr_valid = 1'b1; end
            M_PAGE:  begin addr = page_addr; addr_valid = 1'b1; end
            default: begin addr = '0;        addr_valid = 1'b0; end
        endcase
    end

    // R1: selector and flag clear on reset
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (sel_q == '0 && !cmp_flag));

    // R7: selector reload visible one edge later
    a_r7_sel_reload: assert property (@(posedge clk) disable iff (rst)
        sel_load |=> sel_q == $past(sel_val));

    // R8: the flag moves only in compare mode
    a_r8_flag_hold: assert property (@(posedge clk) disable iff (rst)
        (mode != M_CMP) |=> $stable(cmp_flag));

    // R10: idle and compare drive no address
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode == M_IDLE || mode == M_CMP) |-> (!addr_valid && addr == '0));

endmodule

// File: tb/ptr_addr_gen_tb.sv
module ptr_addr_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 25;

    typedef struct packed {
        logic [3:0]  rq;
        logic [1:0]  mode;
        logic [2:0]  upd;
        logic [1:0]  cond;
        logic        sl;
        logic [2:0]  sv;
        logic        pl;
        logic [8:0]  pv;
        logic        we;
        logic [2:0]  ws;
        logic [15:0] wd;
        logic [6:0]  off;
        logic [15:0] ea;
        logic        ev;
        logic        ef;
    } vec_t;

    // rq, mode, upd, cond, sl, sv, pl, pv, we, ws, wd, off, exp addr, exp valid, exp flag
    localparam vec_t VECS [NVEC] = '{
        '{4'd10, 2'd0, 3'd1, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b1, 3'd0, 16'h0004, 7'h00, 16'h0000, 1'b0, 1'b0}, // R10 idle, write R0
        '{4'd9,  2'd0, 3'd0, 2'd0, 1'b1, 3'd1, 1'b0, 9'h000, 1'b1, 3'd1, 16'h0100, 7'h00, 16'h0000, 1'b0, 1'b0}, // R9 write reg1, select 1
        '{4'd2,  2'd1, 3'd1, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0100, 1'b1, 1'b0}, // R2 pre-update, +1
        '{4'd3,  2'd1, 3'd3, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0101, 1'b1, 1'b0}, // R3 +R0
        '{4'd3,  2'd1, 3'd4, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0105, 1'b1, 1'b0}, // R3 -R0
        '{4'd3,  2'd1, 3'd2, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0101, 1'b1, 1'b0}, // R3 -1
        '{4'd3,  2'd1, 3'd0, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0100, 1'b1, 1'b0}, // R3 keep
        '{4'd3,  2'd1, 3'd5, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0100, 1'b1, 1'b0}, // R3 code 5 keeps
        '{4'd8,  2'd3, 3'd1, 2'd2, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0000, 1'b0, 1'b0}, // R8 compare GT
        '{4'd8,  2'd0, 3'd0, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0000, 1'b0, 1'b1}, // R8 GT true
        '{4'd8,  2'd3, 3'd1, 2'd1, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0000, 1'b0, 1'b1}, // R8 compare LT
        '{4'd8,  2'd0, 3'd0, 2'd0, 1'b1, 3'd2, 1'b0, 9'h000, 1'b1, 3'd2, 16'hFFFF, 7'h00, 16'h0000, 1'b0, 1'b0}, // R8 LT false
        '{4'd4,  2'd1, 3'd1, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'hFFFF, 1'b1, 1'b0}, // R4 FFFF+1
        '{4'd4,  2'd1, 3'd2, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0000, 1'b1, 1'b0}, // R4 0-1
        '{4'd7,  2'd1, 3'd0, 2'd0, 1'b1, 3'd1, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'hFFFF, 1'b1, 1'b0}, // R7 old selector
        '{4'd9,  2'd1, 3'd1, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b1, 3'd1, 16'h0200, 7'h00, 16'h0100, 1'b1, 1'b0}, // R7 new sel; R9 clash
        '{4'd9,  2'd1, 3'd0, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0200, 1'b1, 1'b0}, // R9 write won
        '{4'd6,  2'd2, 3'd0, 2'd0, 1'b0, 3'd0, 1'b1, 9'h1AB, 1'b0, 3'd0, 16'h0000, 7'h55, 16'h0055, 1'b1, 1'b0}, // R6 old page
        '{4'd5,  2'd2, 3'd1, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h7F, 16'hD5FF, 1'b1, 1'b0}, // R5 page:off
        '{4'd8,  2'd3, 3'd0, 2'd3, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0000, 1'b0, 1'b0}, // R8 compare NE
        '{4'd8,  2'd3, 3'd0, 2'd0, 1'b1, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0000, 1'b0, 1'b1}, // R8 EQ false
        '{4'd8,  2'd3, 3'd0, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0000, 1'b0, 1'b0}, // R8 EQ self
        '{4'd10, 2'd0, 3'd1, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0000, 1'b0, 1'b1}, // R10 idle step ignored
        '{4'd8,  2'd0, 3'd1, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0000, 1'b0, 1'b1}, // R8 flag holds
        '{4'd10, 2'd1, 3'd0, 2'd0, 1'b0, 3'd0, 1'b0, 9'h000, 1'b0, 3'd0, 16'h0000, 7'h00, 16'h0004, 1'b1, 1'b1}  // R10 R0 unchanged
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  acc_mode;
    logic [2:0]  step_code;
    logic [1:0]  cmp_cond;
    logic        sel_load;
    logic [2:0]  sel_val;
    logic        page_load;
    logic [8:0]  page_val;
    logic        reg_we;
    logic [2:0]  reg_widx;
    logic [15:0] reg_wdata;
    logic [6:0]  instr_off;
    logic [15:0] addr;
    logic        addr_valid;
    logic        cmp_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_addr_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .acc_mode   (acc_mode),
        .step_code  (step_code),
        .cmp_cond   (cmp_cond),
        .sel_load   (sel_load),
        .sel_val    (sel_val),
        .page_load  (page_load),
        .page_val   (page_val),
        .reg_we     (reg_we),
        .reg_widx   (reg_widx),
        .reg_wdata  (reg_wdata),
        .instr_off  (instr_off),
        .addr       (addr),
        .addr_valid (addr_valid),
        .cmp_flag   (cmp_flag)
    );

    task automatic check(input int rq, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic quiet();
        acc_mode = 2'd0; step_code = 3'd0; cmp_cond = 2'd0;
        sel_load = 1'b0; sel_val = 3'd0; page_load = 1'b0; page_val = 9'd0;
        reg_we = 1'b0; reg_widx = 3'd0; reg_wdata = 16'd0; instr_off = 7'd0;
    endtask

    task automatic apply(input vec_t v);
        acc_mode = v.mode; step_code = v.upd; cmp_cond = v.cond;
        sel_load = v.sl; sel_val = v.sv; page_load = v.pl; page_val = v.pv;
        reg_we = v.we; reg_widx = v.ws; reg_wdata = v.wd; instr_off = v.off;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        rst = 1'b1;
        quiet();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: state after reset
        check(1, "reset addr_valid", {15'd0, addr_valid}, 16'd0);
        check(1, "reset cmp_flag", {15'd0, cmp_flag}, 16'd0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            #1;
            check(VECS[i].rq, $sformatf("vec %0d addr", i), addr, VECS[i].ea);
            check(VECS[i].rq, $sformatf("vec %0d valid", i), {15'd0, addr_valid}, {15'd0, VECS[i].ev});
            check(VECS[i].rq, $sformatf("vec %0d flag", i), {15'd0, cmp_flag}, {15'd0, VECS[i].ef});
            @(posedge clk);
        end

        // R1: mid-run reset clears registers, selector, page and flag
        @(negedge clk);
        quiet();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(1, "flag after reset", {15'd0, cmp_flag}, 16'd0);
        acc_mode = 2'd2; instr_off = 7'h00;
        #1;
        check(1, "page after reset", addr, 16'h0000);
        acc_mode = 2'd1;
        #1;
        check(1, "sel/R0 after reset", addr, 16'h0000);
        sel_load = 1'b1; sel_val = 3'd1; acc_mode = 2'd0;
        @(posedge clk);
        @(negedge clk);
        quiet();
        acc_mode = 2'd1;
        #1;
        check(1, "reg1 after reset", addr, 16'h0000);
        check(2, "pointer valid", {15'd0, addr_valid}, 16'd1);

        // R3: add register zero when register zero is zero leaves value unchanged, then +1 wraps none
        step_code = 3'd3;
        @(posedge clk);
        @(negedge clk);
        step_code = 3'd0;
        #1;
        check(3, "add zero step", addr, 16'h0000);

        @(negedge clk);
        quiet();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule